// File: doc/BRIEF.md
# Store Queue with Commit, In-Order Writeback and Squash

This block holds the stores of an out-of-order core between dispatch and the moment the data cache has taken them. Stores enter at the tail in program order, each carrying an address, data, a byte size and a sequence number. A commit input names the youngest retired sequence number. Every store from the head up to that number becomes eligible for writeback. A writeback pointer then offers eligible stores one at a time to a data-cache request port, which uses a valid/ready handshake. If the cache refuses a request, that request is held until a retry strobe arrives. Completions come back tagged with the slot index, in any order. Slots are released at the head, but only across an unbroken run of completed stores. A squash input removes younger stores that are not yet committed, working back from the tail.

The ring has DEPTH usable slots plus one spare slot, so N = DEPTH + 1 physical slots. Full and empty are told apart by pointer comparison alone. The writeback port is driven by a two-state machine. In WB_RUN, the store at the writeback pointer is issued when it is eligible. A refusal takes the path RUN-to-BLOCKED. In WB_BLOCKED, the port stays silent unless the retry strobe is high. A retry that is accepted takes the path BLOCKED-to-RUN and advances the pointer. A retry that is refused keeps the machine in WB_BLOCKED.

Top module: `store_queue`

## Requirements
- R1: After reset, the queue reports empty high, full low, free_cnt equal to DEPTH, and no cache request.
- R2: Each accepted allocation takes the slot at the tail. Slot indices count from 0 after reset and wrap from N-1 to 0, where N = DEPTH + 1. free_cnt equals DEPTH minus the number of held stores, full is high exactly when DEPTH stores are held, and empty is high exactly when none are held.
- R3: An allocation while full changes no state, and alloc_err is high in that same cycle.
- R4: A commit with number S marks stores as eligible starting at the head, for as long as each store's sequence number is at most S. The walk stops at the first younger store. A store that is not marked is never requested.
- R5: Stores are requested strictly in allocation order, at most one per cycle. Each request carries the store's slot index, address, data and size. A request made in WB_RUN appears in the cycle after the commit that made the store eligible.
- R6: A store of size 0 is never requested. It counts as complete in the cycle the writeback pointer reaches it, and the pointer moves on.
- R7: After a refused request, req_valid stays low until retry is high. While retry is high, the same store is offered again. Once that offer is accepted, writeback continues with the next store.
- R8: A completion for a slot other than the head only marks that slot. When the head is complete, the head moves past it and past every following completed slot in the same cycle, and all of those slots are freed.
- R9: A squash with number Q removes stores from the tail backwards while each one has a sequence number above Q and is not committed. It stops at the first committed store.
- R10: When squash and allocation fall in the same cycle, the allocation is dropped without alloc_err. When commit and squash fall in the same cycle, the commit is applied first, so a store committed in that cycle survives the squash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store this cycle |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Store size in bytes, 0 means no memory access |
| alloc_seq | input | SEQ_W | Store sequence number |
| commit_valid | input | 1 | Commit strobe |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| req_valid | output | 1 | Cache write request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_idx | output | IDX_W | Slot index of the requested store |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_size | output | SIZE_W | Request size |
| retry | input | 1 | Cache retry strobe for a refused request |
| cmp_valid | input | 1 | Completion response valid |
| cmp_idx | input | IDX_W | Slot index being completed |
| free_cnt | output | CNT_W | Number of free slots |
| full | output | 1 | No free slot |
| empty | output | 1 | No store held |
| alloc_err | output | 1 | Allocation attempted while full |

## Verification
The overlaps that matter here are squash with allocation, squash with commit, and head retirement with a fresh allocation or squash. A directed sequence drives commit, squash and alloc in a single cycle. In that cycle the bench expects the just-committed store to survive, the next store to be removed, and alloc_err to stay low. A cycle-accurate reference model in the bench then runs random traffic, with overlapping commits, squashes, refusals, retries and out-of-order completions. On every cycle it compares the free count, the flags and the contents of each request.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [0:0] {
        WB_RUN     = 1'b0,
        WB_BLOCKED = 1'b1
    } wb_state_e;
endpackage

// File: rtl/sq_wb_fsm.sv
module sq_wb_fsm
    import sq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eligible,
    input  logic zero_size,
    input  logic req_ready,
    input  logic retry,
    output logic req_valid,
    output logic wb_adv,
    output logic zero_done
);
    wb_state_e state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WB_RUN;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n   = state_q;
        req_valid = 1'b0;
        wb_adv    = 1'b0;
        zero_done = 1'b0;
        unique case (state_q)
            WB_RUN: begin
                if (eligible) begin
                    if (zero_size) begin
                        zero_done = 1'b1;
                        wb_adv    = 1'b1;
                    end else begin
                        req_valid = 1'b1;
                        if (req_ready) wb_adv = 1'b1;
                        else           state_n = WB_BLOCKED;
                    end
                end
            end
            WB_BLOCKED: begin
                req_valid = retry;
                if (retry && req_ready) begin
                    wb_adv  = 1'b1;
                    state_n = WB_RUN;
                end
            end
            default: state_n = WB_RUN;
        endcase
    end

    // R7: a refused request is not followed by another one without retry
    assert_hold_until_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (!req_valid || retry));
endmodule

// File: rtl/sq_retire.sv
module sq_retire #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] tail,
    input  logic [N-1:0]     done_vec,
    output logic [IDX_W-1:0] head_next,
    output logic [N-1:0]     ret_mask
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    logic [IDX_W-1:0] rp;
    logic             rstop;

    always_comb begin
        ret_mask = '0;
        rp       = head;
        rstop    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!rstop) begin
                if (rp != tail && done_vec[rp]) begin
                    ret_mask[rp] = 1'b1;
                    rp = idx_inc(rp);
                end else begin
                    rstop = 1'b1;
                end
            end
        end
        head_next = rp;
    end
endmodule

// File: rtl/store_queue.sv
module store_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4,
    parameter int SEQ_W  = 16,
    localparam int N     = DEPTH + 1,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [IDX_W-1:0]  req_idx,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [SIZE_W-1:0] req_size,
    input  logic              retry,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              full,
    output logic              empty,
    output logic              alloc_err
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] idx_dec(input logic [IDX_W-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    logic [IDX_W-1:0]  head_q, tail_q, wb_q;
    logic [N-1:0]      valid_q, canwb_q, done_q;
    logic [ADDR_W-1:0] addr_q [N];
    logic [DATA_W-1:0] data_q [N];
    logic [SIZE_W-1:0] size_q [N];
    logic [SEQ_W-1:0]  seq_q  [N];

    logic [N-1:0]      canwb_c, kill_c, done_c, ret_mask;
    logic [IDX_W-1:0]  head_n, tail_sq, cp, sp, sq;
    logic              cstop, sstop;
    logic              eligible, wb_adv, zero_done, alloc_ok;
    logic [IDX_W:0]    occ;

    // occupancy and flags
    always_comb begin
        if (tail_q >= head_q) occ = {1'b0, tail_q} - {1'b0, head_q};
        else                  occ = {1'b0, tail_q} + (IDX_W+1)'(N) - {1'b0, head_q};
    end
    assign free_cnt  = CNT_W'(DEPTH) - CNT_W'(occ);
    assign full      = (idx_inc(tail_q) == head_q);
    assign empty     = (tail_q == head_q);
    assign alloc_err = alloc_valid && full;
    assign alloc_ok  = alloc_valid && !full && !squash_valid;

    // commit walk from head
    always_comb begin
        canwb_c = canwb_q;
        cp      = head_q;
        cstop   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!cstop && commit_valid && cp != tail_q) begin
                if (seq_q[cp] <= commit_seq) begin
                    canwb_c[cp] = 1'b1;
                    cp = idx_inc(cp);
                end else begin
                    cstop = 1'b1;
                end
            end
        end
    end

    // squash walk back from tail, after commit
    always_comb begin
        kill_c = '0;
        sp     = tail_q;
        sq     = tail_q;
        sstop  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!sstop && squash_valid && sp != head_q) begin
                sq = idx_dec(sp);
                if (!canwb_c[sq] && seq_q[sq] > squash_seq) begin
                    kill_c[sq] = 1'b1;
                    sp = sq;
                end else begin
                    sstop = 1'b1;
                end
            end
        end
        tail_sq = sp;
    end

    // completion merge
    always_comb begin
        done_c = done_q;
        if (cmp_valid) done_c[cmp_idx] = 1'b1;
        if (zero_done) done_c[wb_q]    = 1'b1;
    end

    sq_retire #(.N(N), .IDX_W(IDX_W)) u_retire (
        .head      (head_q),
        .tail      (tail_q),
        .done_vec  (done_c),
        .head_next (head_n),
        .ret_mask  (ret_mask)
    );

    assign eligible = (wb_q != tail_q) && valid_q[wb_q] && canwb_q[wb_q];

    sq_wb_fsm u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .eligible  (eligible),
        .zero_size (size_q[wb_q] == '0),
        .req_ready (req_ready),
        .retry     (retry),
        .req_valid (req_valid),
        .wb_adv    (wb_adv),
        .zero_done (zero_done)
    );

    assign req_idx  = wb_q;
    assign req_addr = addr_q[wb_q];
    assign req_data = data_q[wb_q];
    assign req_size = size_q[wb_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            wb_q    <= '0;
            valid_q <= '0;
            canwb_q <= '0;
            done_q  <= '0;
        end else begin
            head_q  <= head_n;
            if (wb_adv) wb_q <= idx_inc(wb_q);
            valid_q <= valid_q & ~kill_c & ~ret_mask;
            canwb_q <= canwb_c & ~ret_mask;
            done_q  <= done_c & ~ret_mask;
            if (squash_valid) begin
                tail_q <= tail_sq;
            end else if (alloc_ok) begin
                tail_q          <= idx_inc(tail_q);
                valid_q[tail_q] <= 1'b1;
                canwb_q[tail_q] <= 1'b0;
                done_q[tail_q]  <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_ok) begin
            addr_q[tail_q] <= alloc_addr;
            data_q[tail_q] <= alloc_data;
            size_q[tail_q] <= alloc_size;
            seq_q[tail_q]  <= alloc_seq;
        end
    end

    // R3: allocation while full leaves the tail where it was
    assert_full_alloc_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && full && !squash_valid) |=> $stable(tail_q));
    // R2: full and the free count agree
    assert_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (free_cnt == '0) && !empty);
    // R5: an accepted request moves writeback by exactly one slot
    assert_wb_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (wb_q == idx_inc($past(wb_q))));
    // R6: zero-size stores never reach the cache
    assert_no_zero_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_size != '0));
    // R4: only committed stores are requested
    assert_req_committed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> canwb_q[wb_q]);
endmodule

// File: tb/store_queue_test.sv
module store_queue_test;
    localparam int DEPTH = 4;
    localparam int N     = DEPTH + 1;
    localparam int IDX_W = 3;
    localparam int CNT_W = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid;
    logic [31:0] alloc_addr;
    logic [63:0] alloc_data;
    logic [3:0]  alloc_size;
    logic [15:0] alloc_seq;
    logic        commit_valid;
    logic [15:0] commit_seq;
    logic        squash_valid;
    logic [15:0] squash_seq;
    logic        req_valid;
    logic        req_ready;
    logic [IDX_W-1:0] req_idx;
    logic [31:0] req_addr;
    logic [63:0] req_data;
    logic [3:0]  req_size;
    logic        retry;
    logic        cmp_valid;
    logic [IDX_W-1:0] cmp_idx;
    logic [CNT_W-1:0] free_cnt;
    logic        full, empty, alloc_err;

    store_queue uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
        .alloc_size(alloc_size), .alloc_seq(alloc_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
        .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
        .retry(retry), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
        .free_cnt(free_cnt), .full(full), .empty(empty), .alloc_err(alloc_err)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int nextseq = 1;
    int cmax = 0;

    // reference model state
    bit          mc [N];
    bit          md [N];
    bit          ms [N];
    int          mseq [N];
    int          msz [N];
    logic [31:0] maddr [N];
    logic [63:0] mdat [N];
    int          mh = 0, mt = 0, mw = 0;
    bit          mblk = 0;

    function automatic int rinc(int p); return (p + 1) % N; endfunction
    function automatic int rdec(int p); return (p + N - 1) % N; endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_addr = '0; alloc_data = '0; alloc_size = '0; alloc_seq = '0;
        commit_valid = 0; commit_seq = '0; squash_valid = 0; squash_seq = '0;
        req_ready = 1; retry = 0; cmp_valid = 0; cmp_idx = '0;
    endtask

    task automatic put(int addr, int size);
        alloc_valid = 1; alloc_addr = 32'(addr); alloc_data = {32'(addr), 32'hA5A5_0000 + 32'(nextseq)};
        alloc_size = 4'(size); alloc_seq = 16'(nextseq); nextseq++;
    endtask

    // one cycle: compare outputs against the model, then advance the model
    task automatic cyc();
        int occ, efree, p, q, ntail;
        bit efull, eempty, elig, ereq, zero, adv;
        #1;
        occ    = (mt - mh + N) % N;
        efree  = DEPTH - occ;
        efull  = (occ == DEPTH);
        eempty = (occ == 0);
        elig   = (mw != mt) && mc[mw];
        ereq   = mblk ? retry : (elig && msz[mw] != 0);
        chk("R2", "free_cnt", free_cnt, efree);
        chk("R2", "full", full, efull);
        chk("R2", "empty", empty, eempty);
        chk("R3", "alloc_err", alloc_err, alloc_valid && efull);
        chk(mblk ? "R7" : "R5", "req_valid", req_valid, ereq);
        if (ereq) begin
            chk("R5", "req_idx", req_idx, mw);
            chk("R5", "req_addr", req_addr, maddr[mw]);
            chk("R5", "req_data", req_data[31:0], mdat[mw][31:0]);
            chk("R5", "req_size", req_size, msz[mw]);
        end
        zero = !mblk && elig && msz[mw] == 0;
        adv  = zero || (ereq && req_ready);
        if (ereq && req_ready) ms[mw] = 1;
        if (cmp_valid) md[cmp_idx] = 1;
        if (zero) md[mw] = 1;
        mblk = mblk ? !(retry && req_ready) : (ereq && !req_ready);
        if (adv) mw = rinc(mw);
        if (commit_valid) begin
            p = mh;
            while (p != mt && mseq[p] <= int'(commit_seq)) begin mc[p] = 1; p = rinc(p); end
        end
        ntail = mt;
        if (squash_valid) begin
            p = mt;
            while (p != mh) begin
                q = rdec(p);
                if (!mc[q] && mseq[q] > int'(squash_seq)) p = q; else break;
            end
            ntail = p;
        end
        p = mh;
        while (p != mt && md[p]) begin mc[p] = 0; md[p] = 0; ms[p] = 0; p = rinc(p); end
        mh = p;
        if (squash_valid) mt = ntail;
        else if (alloc_valid && !efull) begin
            mc[mt] = 0; md[mt] = 0; ms[mt] = 0; mseq[mt] = alloc_seq; msz[mt] = alloc_size;
            maddr[mt] = alloc_addr; mdat[mt] = alloc_data; mt = rinc(mt);
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int st;
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "free after reset", free_cnt, DEPTH);
        chk("R1", "empty after reset", empty, 1);
        chk("R1", "full after reset", full, 0);
        chk("R1", "req after reset", req_valid, 0);
        cyc();
        // fill: seq1..4, second store has size 0
        put(100, 4); cyc();
        put(200, 0); cyc();
        put(300, 4); cyc();
        put(400, 8); cyc();
        #1 chk("R2", "full after DEPTH allocs", full, 1);
        put(500, 4);
        #1 chk("R3", "alloc_err when full", alloc_err, 1);
        cyc();
        #1 chk("R3", "free unchanged after refused alloc", free_cnt, 0);
        commit_valid = 1; commit_seq = 16'd2; cmax = 2; cyc();
        #1 chk("R4", "committed head requested", req_valid, 1);
        chk("R5", "first request slot", req_idx, 0);
        cyc();
        #1 chk("R6", "zero-size store not requested", req_valid, 0);
        cyc();
        #1 chk("R4", "uncommitted store not requested", req_valid, 0);
        chk("R8", "done non-head does not free", free_cnt, 0);
        cmp_valid = 1; cmp_idx = 3'd0; cyc();
        #1 chk("R8", "head jumps completed run", free_cnt, 2);
        commit_valid = 1; commit_seq = 16'd3; cmax = 3;
        squash_valid = 1; squash_seq = 16'd3; put(600, 4);
        #1 chk("R10", "no alloc_err under squash", alloc_err, 0);
        cyc();
        #1 chk("R9", "squash removed one store", free_cnt, 3);
        chk("R10", "committed-in-same-cycle store requested", req_valid, 1);
        chk("R10", "surviving slot", req_idx, 2);
        req_ready = 0; cyc();
        #1 chk("R7", "silent while blocked", req_valid, 0);
        cyc();
        retry = 1;
        #1 chk("R7", "retry reoffers", req_valid, 1);
        chk("R7", "retry same slot", req_idx, 2);
        cyc();
        cmp_valid = 1; cmp_idx = 3'd2; cyc();
        #1 chk("R8", "empty after last completion", empty, 1);
        cyc();
        // random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 3 == 0) put($urandom, ($urandom % 4 == 0) ? 0 : (1 << ($urandom % 4)));
            if ($urandom % 4 == 0) begin
                cmax = cmax + int'($urandom % 3);
                if (cmax > nextseq - 1) cmax = nextseq - 1;
                commit_valid = 1; commit_seq = 16'(cmax);
            end
            if ($urandom % 20 == 0) begin
                squash_valid = 1; squash_seq = 16'(cmax + int'($urandom % 4));
            end
            req_ready = ($urandom % 4 != 0);
            retry = ($urandom % 3 == 0);
            if ($urandom % 2 == 0) begin
                st = int'($urandom % N);
                for (int k = 0; k < N; k++) begin
                    if (!cmp_valid && ms[(st + k) % N] && !md[(st + k) % N]) begin
                        cmp_valid = 1; cmp_idx = IDX_W'((st + k) % N);
                    end
                end
            end
            cyc();
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule